// File: doc/BRIEF.md
# Interrupt Status Flag Register with Read-to-Clear

This block gathers three one-cycle event strobes (a periodic tick, an alarm match and an end-of-update notice) into sticky status flags. It presents them as an 8-bit status byte and drives an active-low interrupt request. Each source has its own enable bit, supplied by a neighbouring control register. A source whose enable is off still records its flag but does not raise the request. A host read strobe returns the status byte in that cycle and clears the flags on the following clock edge. An event that lands in the same cycle as the read is not lost.

Each of the three flags is held by its own two-state machine. `FLG_IDLE` means nothing is pending and `FLG_HELD` means an event has been recorded. The machine goes `FLG_IDLE -> FLG_HELD` on an event, with or without a read in that cycle. It goes `FLG_HELD -> FLG_IDLE` on a read with no event in the same cycle. It stays in `FLG_HELD` on a read with a coincident event, and in every other case it keeps its state. A small combinational summary stage masks the flags with their enables and produces the summary bit and the request line.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset `reg_c` reads 0x00 and `irq_n` is 1.
- R2: A pulse on any event input sets that source's flag from the next clock edge, whatever its enable bit is.
- R3: In `reg_c`, bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. Bits 3:0 always read 0.
- R4: While `rd_c` is 1, `reg_c` shows the current flags. From the next clock edge, every flag that had no event in the read cycle reads 0.
- R5: An event arriving in the same cycle as `rd_c` leaves its flag set after the read, so the flag shows on the next read.
- R6: Bit 7 of `reg_c` is 1 exactly when some flag is set whose enable is 1. `src_en[2]`, `src_en[1]` and `src_en[0]` enable the periodic, alarm and update-ended flags.
- R7: `irq_n` is 0 exactly while bit 7 of `reg_c` is 1. A change of `src_en` takes effect in the same cycle.
- R8: With no event and no read, every flag keeps its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_periodic | input | 1 | One-cycle periodic tick strobe |
| evt_alarm | input | 1 | One-cycle alarm match strobe |
| evt_update | input | 1 | One-cycle update-ended strobe |
| src_en | input | 3 | Source enables {periodic, alarm, update} |
| rd_c | input | 1 | Host read strobe for the status byte |
| reg_c | output | 8 | Status byte {summary, periodic, alarm, update, 4'b0} |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Single events with all enables off show that each flag latches on its own and lands in its own bit, without raising the request. Enables are then toggled while flags are held, which separates the masking path from the latching path and shows the request following the enable at once. Reads are issued both alone and together with each kind of event, which separates a proper clear from a lost or a stuck flag. A long pseudo-random stretch mixes all strobes and enables, and catches any wrong state-transition priority.

// File: rtl/irqflag_pkg.sv
package irqflag_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_SRC  = 3;
    localparam int SRC_LSB  = 4;
    localparam int SUM_BIT  = REG_W - 1;
    localparam int PAD_W    = SRC_LSB;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_HELD = 1'b1
    } flag_state_e;
endpackage

// File: rtl/irqflag_cell.sv
module irqflag_cell
    import irqflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_i,
    output logic held_o
);
    flag_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (evt_i)          state_d = FLG_HELD;
            FLG_HELD: if (rd_i && !evt_i) state_d = FLG_IDLE;
            default:                      state_d = FLG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FLG_HELD: held_o = 1'b1;
            default:  held_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqflag_summary.sv
module irqflag_summary #(
    parameter int N = 3
) (
    input  logic [N-1:0] held_i,
    input  logic [N-1:0] en_i,
    output logic         sum_o,
    output logic         irq_n_o
);
    logic [N-1:0] masked;

    always_comb begin
        masked  = held_i & en_i;
        sum_o   = |masked;
        irq_n_o = ~(|masked);
    end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irqflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_periodic,
    input  logic             evt_alarm,
    input  logic             evt_update,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic             rd_c,
    output logic [REG_W-1:0] reg_c,
    output logic             irq_n
);
    logic [NUM_SRC-1:0] src_evt;
    logic [NUM_SRC-1:0] held;
    logic               sum_bit;

    assign src_evt = {evt_periodic, evt_alarm, evt_update};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irqflag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (src_evt[g]),
            .rd_i   (rd_c),
            .held_o (held[g])
        );
    end

    irqflag_summary #(.N(NUM_SRC)) u_sum (
        .held_i  (held),
        .en_i    (src_en),
        .sum_o   (sum_bit),
        .irq_n_o (irq_n)
    );

    assign reg_c = {sum_bit, held, {PAD_W{1'b0}}};
endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_periodic,
    input logic       evt_alarm,
    input logic       evt_update,
    input logic [2:0] src_en,
    input logic       rd_c,
    input logic [7:0] reg_c,
    input logic       irq_n
);
    logic [2:0] ev;
    assign ev = {evt_periodic, evt_alarm, evt_update};

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev[2] |=> reg_c[6]);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && ev == 3'b000) |=> (reg_c[6:4] == 3'b000));

    a_r5_keep_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && ev[0]) |=> reg_c[4]);

    a_r6_summary_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        reg_c[7] |-> ((reg_c[6:4] & src_en) != 3'b000));

    a_r7_irq_on_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_c[5] && src_en[1]) |-> !irq_n);

    a_r8_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_c && ev == 3'b000) |=> $stable(reg_c[6:4]));
endmodule

bind irq_flag_reg irq_flag_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .src_en       (src_en),
    .rd_c         (rd_c),
    .reg_c        (reg_c),
    .irq_n        (irq_n)
);

// File: tb/tb_irq_flag_reg.sv
`timescale 1ns/1ps
module tb_irq_flag_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
    logic [2:0] src_en = 3'b000;
    logic       rd_c = 1'b0;
    logic [7:0] reg_c;
    logic       irq_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model flags: periodic, alarm, update
    bit m_p, m_a, m_u;

    always #2 clk = ~clk;

    irq_flag_reg dut (
        .clk(clk), .rst_n(rst_n),
        .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
        .src_en(src_en), .rd_c(rd_c), .reg_c(reg_c), .irq_n(irq_n)
    );

    function automatic logic [7:0] model_c();
        logic sum;
        sum = (m_p & src_en[2]) | (m_a & src_en[1]) | (m_u & src_en[0]);
        return {sum, m_p, m_a, m_u, 4'b0000};
    endfunction

    task automatic check(input string tag, input logic [7:0] got_c, input logic got_irq);
        logic [7:0] e_c;
        e_c = model_c();
        n_run++;
        if (got_c !== e_c) begin
            n_fail++;
            $display("FAIL %s reg_c actual=%02h expected=%02h", tag, got_c, e_c);
        end
        n_run++;
        if (got_irq !== ~e_c[7]) begin
            n_fail++;
            $display("FAIL %s irq_n actual=%b expected=%b", tag, got_irq, ~e_c[7]);
        end
    endtask

    // drive at negedge, compare, then advance model on the edge
    task automatic step(input logic p, input logic a, input logic u, input logic rd,
                        input logic [2:0] en, input string tag);
        evt_periodic = p; evt_alarm = a; evt_update = u; rd_c = rd; src_en = en;
        #1;
        check(tag, reg_c, irq_n);
        @(posedge clk);
        if (rd) begin m_p = 0; m_a = 0; m_u = 0; end
        if (p) m_p = 1;
        if (a) m_a = 1;
        if (u) m_u = 1;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        m_p = 0; m_a = 0; m_u = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(0,0,0,0,3'b000,"R1");
        // R2/R3: each event alone, enables off
        step(1,0,0,0,3'b000,"R2");
        step(0,0,0,0,3'b000,"R3 periodic bit6");
        step(0,0,0,1,3'b000,"R4 read returns");
        step(0,1,0,0,3'b000,"R4 cleared");
        step(0,0,0,0,3'b000,"R3 alarm bit5");
        step(0,0,0,1,3'b000,"R4");
        step(0,0,1,0,3'b000,"R4");
        step(0,0,0,0,3'b000,"R3 update bit4");
        // R8: hold with no activity
        step(0,0,0,0,3'b000,"R8");
        step(0,0,0,0,3'b000,"R8");
        // R6/R7: enable while held, masking
        step(0,0,0,0,3'b110,"R6 update masked");
        step(0,0,0,0,3'b001,"R7 enable raises irq");
        step(0,0,0,0,3'b000,"R7 disable drops irq");
        step(1,0,0,0,3'b100,"R6");
        step(0,0,0,0,3'b100,"R7 periodic enabled");
        step(0,0,0,1,3'b100,"R4");
        // R5: collision of read and event
        step(0,1,0,1,3'b010,"R4 cleared all");
        step(0,0,0,0,3'b010,"R5 alarm kept");
        step(1,0,1,1,3'b111,"R5");
        step(0,0,0,0,3'b111,"R5 kept after read");
        step(0,0,0,1,3'b111,"R4");
        step(0,0,0,0,3'b111,"R4 empty");
        // mixed pseudo-random stretch
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[5], lfsr[1] & lfsr[6], lfsr[2] & lfsr[7],
                 lfsr[3] & lfsr[8], lfsr[11:9], "R6 R7 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule